// File: doc/BRIEF.md
# Vertical Blank Interrupt Status Controller

This block holds the interrupt status and enable state of a display controller and drives one level-sensitive interrupt line. Event inputs set bits in a status register, and each set bit stays set until software clears it. A control register holds one enable bit for each status bit. The interrupt line is high whenever at least one status bit is set and its enable bit is also set.

Software clears status bits by writing 1s to the status register. A write can clear only the bits in a fixed clear mask, and the build variant selects that mask. Bits outside the mask stay set until reset.

The vertical-blank bit has its own source, chosen at build time. One choice is an internal frame timer that ticks every `FRAME_CYCLES` clocks. The other choice is an external frame-start pulse. Writing the control register with the vertical-blank enable set raises a vertical-blank event in the same cycle and restarts the frame period. Writing it with that enable clear stops the source.

Top module: `vblank_irq_ctl`

## Requirements
- R1: After reset, the control and status registers read zero and `irq` is low. While the vertical-blank enable (bit 0) stays clear, no vertical-blank event reaches status, however long the wait.
- R2: `irq` is high exactly when some status bit and its matching control bit are both 1. It follows each register write or latched event one clock later.
- R3: With `VARIANT`=0, a status write (`reg_sel`=1) clears each bit written as 1 that lies in the mask 0x000F040F. Status bits outside that mask do not change.
- R4: With `VARIANT`=1, the status clear mask is 0xFC080EFF. A status write leaves every bit outside that mask unchanged.
- R5: A control write (`reg_sel`=0) with bit 0 set raises status bit 0 on the next clock edge, even if bit 0 was already enabled.
- R6: With the timer source enabled, status bit 0 is set again exactly `FRAME_CYCLES` clocks after the enabling control write, and never earlier.
- R7: After a control write with bit 0 clear, status bit 0 is no longer set by the vertical-blank source.
- R8: If an event and a write-1-to-clear hit the same status bit in the same cycle, the bit ends up set.
- R9: `rd_data` returns the control register when `rd_sel`=0 and the status register when `rd_sel`=1. Any bit of `evt_in` that is high for one clock stays latched in status.
- R10: With the pulse source selected, a `frame_pulse` sets status bit 0 only while bit 0 of control is set. A pulse is ignored while that bit is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 1 | Write target: 0 = control, 1 = status (write 1 to clear) |
| reg_wdata | input | DATA_W | Write data |
| rd_sel | input | 1 | Read select: 0 = control, 1 = status |
| rd_data | output | DATA_W | Read data of the selected register |
| evt_in | input | DATA_W | Per-bit event pulses that set status |
| frame_pulse | input | 1 | Frame-start pulse, used when the pulse source is selected |
| irq | output | 1 | Level interrupt output |

## Verification
The assertions assume that `evt_in` and `frame_pulse` are single-cycle pulses that are stable around the clock edge. They also assume that at most one register write happens per cycle. The bench drives every input on the falling edge and holds it for exactly one rising edge. The no-rise check on the vertical-blank bit assumes `evt_in` bit 0 stays low whenever that enable is off. The bench keeps to this by raising `evt_in` bit 0 only in the all-ones mask tests, and reset follows each of those tests.

// File: rtl/vbirq_pkg.sv
package vbirq_pkg;

   typedef enum logic {
      SEL_CTRL = 1'b0,
      SEL_STAT = 1'b1
   } reg_sel_e;

   localparam logic [31:0] CLR_MASK_V0 = 32'h000F_040F;
   localparam logic [31:0] CLR_MASK_V1 = 32'hFC08_0EFF;

   function automatic logic [31:0] clear_mask(input int variant);
      return (variant == 0) ? CLR_MASK_V0 : CLR_MASK_V1;
   endfunction

endpackage

// File: rtl/vbirq_timer.sv
module vbirq_timer #(
   parameter int FRAME_CYCLES = 1666667
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   input  logic restart,
   input  logic halt,
   output logic tick
);
   localparam int CNT_W = (FRAME_CYCLES > 2) ? $clog2(FRAME_CYCLES) : 1;
   localparam logic [CNT_W-1:0] LAST = CNT_W'(FRAME_CYCLES - 1);

   logic [CNT_W-1:0] cnt_q;
   logic             at_end;

   assign at_end = (cnt_q == LAST);
   assign tick   = run && !restart && !halt && at_end;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || halt || !run || at_end) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end
endmodule

// File: rtl/vbirq_src.sv
module vbirq_src #(
   parameter int FRAME_CYCLES = 1666667,
   parameter bit USE_PULSE    = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic enabled,
   input  logic arm,
   input  logic disarm,
   input  logic frame_pulse,
   output logic vb_evt
);
   logic periodic;

   generate
      if (USE_PULSE) begin : g_pulse
         assign periodic = enabled && !disarm && frame_pulse;
         logic unused_clk_rst;
         assign unused_clk_rst = clk ^ rst_n;
      end else begin : g_timer
         logic unused_pulse;
         assign unused_pulse = frame_pulse;
         vbirq_timer #(.FRAME_CYCLES(FRAME_CYCLES)) u_timer (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (enabled),
            .restart(arm),
            .halt   (disarm),
            .tick   (periodic)
         );
      end
   endgenerate

   assign vb_evt = arm || periodic;
endmodule

// File: rtl/vbirq_status.sv
module vbirq_status #(
   parameter int              DATA_W   = 32,
   parameter logic [DATA_W-1:0] CLR_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] set_vec,
   input  logic [DATA_W-1:0] clr_vec,
   output logic [DATA_W-1:0] status_q
);
   genvar b;
   generate
      for (b = 0; b < DATA_W; b++) begin : g_bit
         if (CLR_MASK[b]) begin : g_clearable
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)          status_q[b] <= 1'b0;
               else if (set_vec[b]) status_q[b] <= 1'b1;
               else if (clr_vec[b]) status_q[b] <= 1'b0;
            end
         end else begin : g_sticky
            logic unused_clr;
            assign unused_clr = clr_vec[b];
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n)          status_q[b] <= 1'b0;
               else if (set_vec[b]) status_q[b] <= 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/vblank_irq_ctl.sv
module vblank_irq_ctl #(
   parameter int DATA_W       = 32,
   parameter int VARIANT      = 0,
   parameter int VB_BIT       = 0,
   parameter int FRAME_CYCLES = 1666667,
   parameter bit USE_PULSE    = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic              reg_sel,
   input  logic [DATA_W-1:0] reg_wdata,
   input  logic              rd_sel,
   output logic [DATA_W-1:0] rd_data,
   input  logic [DATA_W-1:0] evt_in,
   input  logic              frame_pulse,
   output logic              irq
);
   import vbirq_pkg::*;

   localparam logic [DATA_W-1:0] CLR_MASK = DATA_W'(clear_mask(VARIANT));

   generate
      if (DATA_W < 32) begin : g_bad_width
         $error("DATA_W must be at least 32");
      end
      if (VARIANT != 0 && VARIANT != 1) begin : g_bad_variant
         $error("VARIANT must be 0 or 1");
      end
      if (VB_BIT < 0 || VB_BIT >= DATA_W) begin : g_bad_bit
         $error("VB_BIT out of range");
      end
      if (FRAME_CYCLES < 2) begin : g_bad_period
         $error("FRAME_CYCLES must be at least 2");
      end
   endgenerate

   logic              wr_ctrl, wr_stat, arm, disarm, vb_evt;
   logic [DATA_W-1:0] ctrl_q, status_q, set_vec, clr_vec;

   assign wr_ctrl = reg_wr && (reg_sel_e'(reg_sel) == SEL_CTRL);
   assign wr_stat = reg_wr && (reg_sel_e'(reg_sel) == SEL_STAT);
   assign arm     = wr_ctrl &&  reg_wdata[VB_BIT];
   assign disarm  = wr_ctrl && !reg_wdata[VB_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= reg_wdata;
   end

   vbirq_src #(.FRAME_CYCLES(FRAME_CYCLES), .USE_PULSE(USE_PULSE)) u_src (
      .clk        (clk),
      .rst_n      (rst_n),
      .enabled    (ctrl_q[VB_BIT]),
      .arm        (arm),
      .disarm     (disarm),
      .frame_pulse(frame_pulse),
      .vb_evt     (vb_evt)
   );

   always_comb begin
      set_vec         = evt_in;
      set_vec[VB_BIT] = evt_in[VB_BIT] | vb_evt;
      clr_vec         = wr_stat ? reg_wdata : '0;
   end

   vbirq_status #(.DATA_W(DATA_W), .CLR_MASK(CLR_MASK)) u_stat (
      .clk     (clk),
      .rst_n   (rst_n),
      .set_vec (set_vec),
      .clr_vec (clr_vec),
      .status_q(status_q)
   );

   assign irq     = |(status_q & ctrl_q);
   assign rd_data = rd_sel ? status_q : ctrl_q;
endmodule

// File: rtl/vbirq_chk.sv
module vbirq_chk #(
   parameter int DATA_W  = 32,
   parameter int VARIANT = 0,
   parameter int VB_BIT  = 0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              reg_wr,
   input logic              reg_sel,
   input logic [DATA_W-1:0] reg_wdata,
   input logic [DATA_W-1:0] evt_in,
   input logic [DATA_W-1:0] ctrl_q,
   input logic [DATA_W-1:0] status_q
);
   localparam logic [DATA_W-1:0] MASK = DATA_W'(vbirq_pkg::clear_mask(VARIANT));

   logic arm_w;
   assign arm_w = reg_wr && !reg_sel && reg_wdata[VB_BIT];

   // R3
   sticky_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> ((($past(status_q) & ~MASK) & ~status_q) == '0));

   // R5
   arm_sets_vb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      arm_w |=> status_q[VB_BIT]);

   // R7
   no_vb_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ctrl_q[VB_BIT] && !arm_w && !evt_in[VB_BIT])
      |=> (!status_q[VB_BIT] || $past(status_q[VB_BIT])));

   // R8
   event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|evt_in) |=> ((status_q & $past(evt_in)) == $past(evt_in)));
endmodule

bind vblank_irq_ctl vbirq_chk #(.DATA_W(DATA_W), .VARIANT(VARIANT), .VB_BIT(VB_BIT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .reg_wr   (reg_wr),
   .reg_sel  (reg_sel),
   .reg_wdata(reg_wdata),
   .evt_in   (evt_in),
   .ctrl_q   (ctrl_q),
   .status_q (status_q)
);

// File: tb/vblank_irq_ctl_tb_top.sv
`timescale 1ns/1ps
module vblank_irq_ctl_tb_top;
   localparam int P = 40;

   logic        clk = 0;
   logic        rst_n = 0;
   logic        a_wr = 0, a_sel = 0, a_rdsel = 0, a_fp = 0, a_irq;
   logic [31:0] a_wdata = 0, a_evt = 0, a_rdata;
   logic        b_wr = 0, b_sel = 0, b_rdsel = 0, b_fp = 0, b_irq;
   logic [31:0] b_wdata = 0, b_evt = 0, b_rdata;
   int          checks = 0, failures = 0;
   bit          done = 0;

   always #5 clk = ~clk;

   vblank_irq_ctl #(.VARIANT(0), .FRAME_CYCLES(P), .USE_PULSE(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(a_wr), .reg_sel(a_sel), .reg_wdata(a_wdata),
      .rd_sel(a_rdsel), .rd_data(a_rdata), .evt_in(a_evt), .frame_pulse(a_fp), .irq(a_irq));

   vblank_irq_ctl #(.VARIANT(1), .FRAME_CYCLES(P), .USE_PULSE(1'b1)) dut_p (
      .clk(clk), .rst_n(rst_n), .reg_wr(b_wr), .reg_sel(b_sel), .reg_wdata(b_wdata),
      .rd_sel(b_rdsel), .rd_data(b_rdata), .evt_in(b_evt), .frame_pulse(b_fp), .irq(b_irq));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 0;
      repeat (2) @(negedge clk);
      rst_n = 1;
      @(posedge clk); #1;
   endtask

   task automatic wr_a(input logic sel, input logic [31:0] d);
      @(negedge clk); a_wr = 1; a_sel = sel; a_wdata = d;
      @(posedge clk); #1; a_wr = 0;
   endtask

   task automatic wr_b(input logic sel, input logic [31:0] d);
      @(negedge clk); b_wr = 1; b_sel = sel; b_wdata = d;
      @(posedge clk); #1; b_wr = 0;
   endtask

   task automatic evt_a(input logic [31:0] e);
      @(negedge clk); a_evt = e;
      @(posedge clk); #1; a_evt = 0;
   endtask

   function automatic logic [31:0] rd_a(input logic sel);
      return sel ? dut_i.rd_data : dut_i.rd_data;
   endfunction

   task automatic read_a(input logic sel, output logic [31:0] v);
      a_rdsel = sel; #1; v = a_rdata;
   endtask

   task automatic read_b(input logic sel, output logic [31:0] v);
      b_rdsel = sel; #1; v = b_rdata;
   endtask

   task automatic t_reset();
      logic [31:0] v;
      do_reset();
      read_a(0, v); chk("R1 ctrl after reset", v, 0);
      read_a(1, v); chk("R1 status after reset", v, 0);
      chk("R1 irq after reset", a_irq, 0);
      repeat (3 * P) @(posedge clk);
      #1; read_a(1, v); chk("R1 no vblank while disabled", v, 0);
   endtask

   task automatic t_enable_and_period();
      logic [31:0] v;
      do_reset();
      wr_a(0, 32'h1);
      read_a(1, v); chk("R5 arm sets vblank", v, 32'h1);
      chk("R2 irq with enabled vblank", a_irq, 1);
      read_a(0, v); chk("R9 ctrl readback", v, 32'h1);
      wr_a(1, 32'h1);
      read_a(1, v); chk("R3 vblank cleared", v, 0);
      chk("R2 irq drops after clear", a_irq, 0);
      repeat (P - 2) @(posedge clk);
      #1; read_a(1, v); chk("R6 no early vblank", v, 0);
      @(posedge clk); #1;
      read_a(1, v); chk("R6 vblank at period", v, 32'h1);
      wr_a(0, 32'h1);
      read_a(1, v); chk("R5 re-arm while enabled", v, 32'h1);
   endtask

   task automatic t_stop();
      logic [31:0] v;
      wr_a(0, 32'h0);
      chk("R2 irq low with enable off", a_irq, 0);
      wr_a(1, 32'h1);
      repeat (3 * P) @(posedge clk);
      #1; read_a(1, v); chk("R7 source stopped", v, 0);
   endtask

   task automatic t_mask_v0();
      logic [31:0] v;
      do_reset();
      evt_a(32'hFFFF_FFFF);
      read_a(1, v); chk("R9 all events latched", v, 32'hFFFF_FFFF);
      wr_a(1, 32'hFFFF_FFFF);
      read_a(1, v); chk("R3 variant0 mask", v, 32'hFFF0_FBF0);
      do_reset();
   endtask

   task automatic t_mask_v1();
      logic [31:0] v;
      do_reset();
      @(negedge clk); b_evt = 32'hFFFF_FFFF;
      @(posedge clk); #1; b_evt = 0;
      wr_b(1, 32'hFFFF_FFFF);
      read_b(1, v); chk("R4 variant1 mask", v, 32'h03F7_F100);
      do_reset();
   endtask

   task automatic t_collide();
      logic [31:0] v;
      do_reset();
      evt_a(32'h2);
      @(negedge clk); a_evt = 32'h2; a_wr = 1; a_sel = 1; a_wdata = 32'h2;
      @(posedge clk); #1; a_evt = 0; a_wr = 0;
      read_a(1, v); chk("R8 event beats clear", v, 32'h2);
      wr_a(1, 32'h2);
      read_a(1, v); chk("R8 plain clear after", v, 0);
   endtask

   task automatic t_other_irq();
      logic [31:0] v;
      do_reset();
      evt_a(32'h400);
      repeat (5) @(posedge clk);
      #1; read_a(1, v); chk("R9 event held", v, 32'h400);
      chk("R2 irq off without enable", a_irq, 0);
      wr_a(0, 32'h400);
      chk("R2 irq on with enable", a_irq, 1);
      read_a(1, v); chk("R5 no arm without bit0", v, 32'h400);
      wr_a(1, 32'h400);
      chk("R2 irq off after clear", a_irq, 0);
   endtask

   task automatic t_pulse();
      logic [31:0] v;
      do_reset();
      @(negedge clk); b_fp = 1;
      @(posedge clk); #1; b_fp = 0;
      read_b(1, v); chk("R10 pulse ignored while off", v, 0);
      wr_b(0, 32'h1);
      wr_b(1, 32'h1);
      read_b(1, v); chk("R10 status cleared before pulse", v, 0);
      repeat (3) @(posedge clk);
      #1; read_b(1, v); chk("R10 no timer in pulse mode", v, 0);
      @(negedge clk); b_fp = 1;
      @(posedge clk); #1; b_fp = 0;
      read_b(1, v); chk("R10 pulse sets vblank", v, 32'h1);
      chk("R2 irq from pulse", b_irq, 1);
   endtask

   initial begin
      t_reset();
      t_enable_and_period();
      t_stop();
      t_mask_v0();
      t_mask_v1();
      t_collide();
      t_other_irq();
      t_pulse();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule